// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of equal width and returns the complete product, twice the operand width, with no truncation. The product is assembled by the vertical-and-crosswise method. A 2x2 leaf cell forms its four AND terms and adds them column by column. Each wider stage splits both operands into halves and forms four half-width sub-products: high times high, low(a) times high(b), high(a) times low(b), and low times low. These are joined through fixed zero-padded additions. The lowest half of the low-times-low product goes straight to the output and passes through no adder.

Every partial product and every sum is computed at the same time, in combinational logic. A parameter can add one output register, which makes the latency one cycle. With that parameter off, the product follows the operands in the same cycle. The operand width must be a power of two and at least 2. The same rule gives a 4x4 multiplier from four 2x2 cells and an 8x8 multiplier from four 4x4 stages.

Top module: `vc_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals op_a times op_b over the full 2*OPW bits.
- R2: Product bit 0 equals op_a[0]&op_b[0]. Product bit 1 equals (op_a[0]&op_b[1]) XOR (op_a[1]&op_b[0]).
- R3: When either operand is zero, `prod` is zero.
- R4: With both operands all ones, `prod` equals 2^(2*OPW) - 2^(OPW+1) + 1. For OPW=8 this is 0xFE01, with nothing lost at the top.
- R5: With REG_OUT=1, `prod` shows the product of the operands sampled at the previous rising clock edge. It holds that value until the next edge.
- R6: With REG_OUT=1, an active-low `rst_n` clears `prod` to zero, and `prod` stays zero while reset is low.
- R7: With REG_OUT=0, `prod` follows the operands combinationally, in the same cycle, with no clock edge needed.
- R8: At OPW=4, the operands 4'b1010 and 4'b1101 give 8'b10000010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | OPW | Unsigned multiplicand |
| op_b | input | OPW | Unsigned multiplier |
| prod | output | 2*OPW | Full unsigned product |

## Verification
An unregistered 4-bit instance is driven through all 256 operand pairs, so every carry pattern in the recombination adders is exercised. A swapped cross term or a mis-sized zero pad would show up as wrong upper bits on some of those pairs. A registered 8-bit instance receives zero operands, all-ones operands and random pairs through a scoreboard. That catches a carry lost at the top, which would turn 0xFE01 into a smaller value, and an off-by-one latency, which would show the product of the wrong pair. The bench also checks the output during reset and the worked example 1010 x 1101, so a register that does not clear, or low bits routed through an adder by mistake, would be reported.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // Two-bit result of a half adder: {carry, sum}
  function automatic logic [1:0] half_add(input logic x, input logic y);
    return {x & y, x ^ y};
  endfunction
endpackage

// File: rtl/vc_cell2.sv
module vc_cell2
  import vc_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic       vert_lo, cross_0, cross_1, vert_hi;
  logic [1:0] col1, col2;

  assign vert_lo = a[0] & b[0];
  assign cross_0 = a[0] & b[1];
  assign cross_1 = a[1] & b[0];
  assign vert_hi = a[1] & b[1];

  assign col1 = half_add(cross_0, cross_1);
  assign col2 = half_add(vert_hi, col1[1]);

  assign p = {col2[1], col2[0], col1[0], vert_lo};
endmodule

// File: rtl/vc_node.sv
module vc_node #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  generate
    if (W == 2) begin : g_leaf
      vc_cell2 u_cell (.a(a), .b(b), .p(p));
    end else begin : g_split
      localparam int H  = W / 2;
      localparam int TW = 3 * H;

      logic [W-1:0]  pp_hh, pp_lh, pp_hl, pp_ll;
      logic [TW-1:0] term_hh, term_lh, term_hl, term_carry;
      logic [TW-1:0] sum_top, sum_mid, sum_all;

      vc_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(pp_hh));
      vc_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(pp_lh));
      vc_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(pp_hl));
      vc_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(pp_ll));

      // high-by-high moves up by H places; the others are zero-padded above
      assign term_hh    = {pp_hh, {H{1'b0}}};
      assign term_lh    = {{H{1'b0}}, pp_lh};
      assign term_hl    = {{H{1'b0}}, pp_hl};
      assign term_carry = {{(TW-H){1'b0}}, pp_ll[W-1:H]};

      assign sum_top = term_hh + term_lh;
      assign sum_mid = term_hl + term_carry;
      assign sum_all = sum_top + sum_mid;

      // lowest H bits bypass every adder
      assign p = {sum_all, pp_ll[H-1:0]};
    end
  endgenerate
endmodule

// File: rtl/vc_mult.sv
module vc_mult #(
  parameter int OPW     = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPW-1:0]    op_a,
  input  logic [OPW-1:0]    op_b,
  output logic [2*OPW-1:0]  prod
);
  localparam int PW = 2 * OPW;

  logic [PW-1:0] prod_comb;

  vc_node #(.W(OPW)) u_tree (.a(op_a), .b(op_b), .p(prod_comb));

  generate
    if (REG_OUT) begin : g_reg
      logic [PW-1:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_comb;
      end
      assign prod = prod_q;
    end else begin : g_comb
      assign prod = prod_comb;
    end
  endgenerate
endmodule

// File: rtl/vc_mult_chk.sv
module vc_mult_chk #(
  parameter int OPW     = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OPW-1:0]    op_a,
  input logic [OPW-1:0]    op_b,
  input logic [2*OPW-1:0]  prod
);
  localparam int PW = 2 * OPW;

  generate
    if (REG_OUT) begin : g_reg_chk
      // R1 R5
      full_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> prod == PW'($past(op_a)) * PW'($past(op_b)));
      // R2
      low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> prod[1:0] ==
          {($past(op_a[0]) & $past(op_b[1])) ^ ($past(op_a[1]) & $past(op_b[0])),
           $past(op_a[0]) & $past(op_b[0])});
      // R3
      zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_a) == '0 || $past(op_b) == '0)) |-> prod == '0);
      // R6
      reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> prod == '0);
    end else begin : g_comb_chk
      // R1 R7
      full_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prod == PW'(op_a) * PW'(op_b));
      // R2
      low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prod[1:0] == {(op_a[0] & op_b[1]) ^ (op_a[1] & op_b[0]), op_a[0] & op_b[0]});
      // R3
      zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a == '0 || op_b == '0) |-> prod == '0);
    end
  endgenerate
endmodule

bind vc_mult vc_mult_chk #(.OPW(OPW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod)
);

// File: tb/vc_mult_test.sv
module vc_mult_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] sb_q[$];

  always #2 clk = ~clk;

  vc_mult #(.OPW(8), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .prod(p8));

  vc_mult #(.OPW(4), .REG_OUT(1'b0)) uut4 (
    .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .prod(p4));

  // reference: shift-and-add over the multiplier bits
  function automatic logic [15:0] ref_mul(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] acc = '0;
    for (int k = 0; k < 8; k++)
      if (y[k]) acc = acc + (16'(x) << k);
    return acc;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive8(input logic [7:0] x, input logic [7:0] y);
    a8 = x;
    b8 = y;
    sb_q.push_back({x, y, ref_mul(x, y)});
  endtask

  // monitor: one cycle of latency, sampled 1 ns after the edge (R5)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        logic [31:0] it;
        it = sb_q.pop_front();
        if (it[31:24] == 8'hFF && it[23:16] == 8'hFF)
          check("R4 all-ones", p8, it[15:0]);
        else if (it[31:24] == 8'h00 || it[23:16] == 8'h00)
          check("R3 zero operand", p8, it[15:0]);
        else
          check("R1/R5 registered product", p8, it[15:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    a8 = 8'hAA;
    b8 = 8'h55;
    repeat (3) @(negedge clk);
    check("R6 reset clears output", p8, 16'h0000);
    rst_n = 1'b1;

    // worked example at 4 bits (R8)
    a4 = 4'b1010;
    b4 = 4'b1101;
    #1;
    check("R8 worked example", {8'h00, p4}, 16'h0082);

    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      a4 = i[7:4];
      b4 = i[3:0];
      case (i)
        0:       drive8(8'h00, 8'h9C);
        1:       drive8(8'hFF, 8'hFF);
        2:       drive8(8'h37, 8'h00);
        3:       drive8(8'h01, 8'hC5);
        4:       drive8(8'h80, 8'h80);
        default: drive8(8'($urandom), 8'($urandom));
      endcase
      #1;
      check("R1/R7 exhaustive 4x4", {8'h00, p4}, ref_mul({4'h0, i[7:4]}, {4'h0, i[3:0]}));
      check("R2 low bits bypass", {14'h0, p4[1:0]},
            {14'h0, (i[4] & i[1]) ^ (i[5] & i[0]), i[4] & i[0]});
    end

    // hold operands steady: output must keep the same product (R5)
    @(negedge clk);
    drive8(8'hC3, 8'h7E);
    @(negedge clk);
    drive8(8'hC3, 8'h7E);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule